// File: doc/BRIEF.md
# Device-to-Memory DMA Copier

This engine copies a block of bytes from a single-byte device port into consecutive memory locations. Software sets a transfer length and a destination address in two configuration registers, then writes a go bit. From that point the processor has no part in the transfer. For each byte, the engine waits until the device reports that a byte is available and reads it. It then writes the byte to memory through a request/acknowledge port and moves to the next address.

When the last byte has been acknowledged by memory, the engine sets a sticky completion flag. That flag drives the interrupt line to the processor, and software clears it by writing a one to it. A length of zero completes at once and writes nothing. A go command that arrives while a transfer is running is dropped. Writes to the length and destination registers during a transfer change only the register values for the next transfer, never the one in progress.

Top module: `dma_dev2mem`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_req` and `dev_rd` are all 0.
- R2: A transfer of N bytes writes to addresses base, base+1, ..., base+N-1 in that order. Here base is the value held at configuration select 1 when the go bit is written, and N is the value held at select 0.
- R3: The engine never asserts `dev_rd` while `dev_ready` is 0. While no byte is available it stays busy, with `mem_req` at 0.
- R4: Each byte is consumed with one single-cycle `dev_rd` pulse. The `dev_data` value seen in that cycle is the byte written to memory, and `mem_req` drops in the cycle after `mem_ack`.
- R5: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.
- R6: Exactly N memory writes are made. The completion flag (`irq`) becomes 1 at the clock edge that accepts the last `mem_ack`, and `busy` returns to 0 at the same edge. While idle, neither `mem_req` nor `dev_rd` is asserted.
- R7: Writing the go bit with N = 0 sets `irq` at that edge, leaves `busy` at 0 and produces no memory write.
- R8: `irq` stays 1 until the control register (select 2) is written with bit 1 set. A control write with bit 1 clear leaves it at 1.
- R9: A go write (select 2, bit 0) while `busy` is 1 is ignored. A destination or length written during a transfer does not affect that transfer.
- R10: `dev_rd` and `mem_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 length, 1 destination, 2 control |
| cfg_wdata | input | AW | Write data. In the control register, bit 0 is go and bit 1 clears the completion flag |
| dev_ready | input | 1 | Device has a byte available |
| dev_data | input | DW | Device byte |
| dev_rd | output | 1 | Read strobe, consumes the device byte |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write byte |
| mem_ack | input | 1 | Memory accepted the write |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The properties assume that the device holds `dev_ready` high until the engine has read the byte. They also assume that memory raises `mem_ack` only while `mem_req` is high, for one cycle per write. The bench's device model drops its ready flag only after it has seen a read strobe. The memory model pulses its acknowledge only against a pending request, after a programmable number of wait cycles, so the stimulus never leaves these assumptions. Device gaps and memory latencies are varied across transfers so that both wait states are exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_POLL  = 2'd1,
        XS_STORE = 2'd2
    } xfer_state_e;

    localparam logic [1:0] SEL_LEN  = 2'd0;
    localparam logic [1:0] SEL_DEST = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef struct packed {
        logic go;
        logic clr;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic we, input logic [1:0] sel,
                                              input logic go_b, input logic clr_b);
        ctrl_cmd_t c;
        c.go  = we && (sel == SEL_CTRL) && go_b;
        c.clr = we && (sel == SEL_CTRL) && clr_b;
        return c;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          done_set,
    output logic [CW-1:0] len_q,
    output logic [AW-1:0] dest_q,
    output ctrl_cmd_t     cmd,
    output logic          done_q
);

    assign cmd = decode_ctrl(cfg_we, cfg_sel, cfg_wdata[CTRL_GO_BIT], cfg_wdata[CTRL_CLR_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            dest_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_LEN)  len_q  <= cfg_wdata[CW-1:0];
            if (cfg_sel == SEL_DEST) dest_q <= cfg_wdata;
        end
    end

    // set has priority over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (done_set) done_q <= 1'b1;
        else if (cmd.clr)  done_q <= 1'b0;
    end

endmodule

// File: rtl/dma_byte_latch.sv
module dma_byte_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst)      dout <= '0;
        else if (cap) dout <= din;
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] len_q,
    input  logic [AW-1:0] dest_q,
    input  logic          dev_ready,
    input  logic          mem_ack,
    output logic          dev_rd,
    output logic          mem_req,
    output logic [AW-1:0] cur_addr,
    output logic          done_set,
    output logic          busy
);

    localparam logic [CW-1:0] LAST_ONE = CW'(1);
    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    xfer_state_e   state;
    logic [CW-1:0] remain;
    logic          start_ok;
    logic          zero_len;
    logic          last_ack;

    assign start_ok = (state == XS_IDLE) && go;
    assign zero_len = (len_q == '0);
    assign last_ack = (state == XS_STORE) && mem_ack && (remain == LAST_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= XS_IDLE;
            remain   <= '0;
            cur_addr <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (go) begin
                        remain   <= len_q;
                        cur_addr <= dest_q;
                        state    <= zero_len ? XS_IDLE : XS_POLL;
                    end
                end
                XS_POLL: begin
                    if (dev_ready) state <= XS_STORE;
                end
                XS_STORE: begin
                    if (mem_ack) begin
                        remain   <= remain - LAST_ONE;
                        cur_addr <= cur_addr + ADDR_STEP;
                        state    <= (remain == LAST_ONE) ? XS_IDLE : XS_POLL;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    assign dev_rd   = (state == XS_POLL) && dev_ready;
    assign mem_req  = (state == XS_STORE);
    assign busy     = (state != XS_IDLE);
    assign done_set = (start_ok && zero_len) || last_ack;

endmodule

// File: rtl/dma_dev2mem.sv
module dma_dev2mem
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dev_ready,
    input  logic [DW-1:0] dev_data,
    output logic          dev_rd,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          irq
);

    logic [CW-1:0] len_q;
    logic [AW-1:0] dest_q;
    ctrl_cmd_t     cmd;
    logic          done_set;

    dma_cfg_regs #(.AW(AW), .CW(CW)) regs_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .done_set(done_set), .len_q(len_q), .dest_q(dest_q), .cmd(cmd), .done_q(irq)
    );

    dma_xfer_fsm #(.AW(AW), .CW(CW)) fsm_i (
        .clk(clk), .rst(rst), .go(cmd.go), .len_q(len_q), .dest_q(dest_q),
        .dev_ready(dev_ready), .mem_ack(mem_ack), .dev_rd(dev_rd), .mem_req(mem_req),
        .cur_addr(mem_addr), .done_set(done_set), .busy(busy)
    );

    dma_byte_latch #(.DW(DW)) latch_i (
        .clk(clk), .rst(rst), .cap(dev_rd), .din(dev_data), .dout(mem_wdata)
    );

endmodule

// File: rtl/dma_dev2mem_chk.sv
module dma_dev2mem_chk #(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          go_wr,
    input logic          clr_wr,
    input logic          dev_ready,
    input logic          dev_rd,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          busy,
    input logic          irq
);

    logic          have_prev;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (!busy && go_wr) begin
            have_prev <= 1'b0;
        end else if (mem_req && mem_ack) begin
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && have_prev) |-> (mem_addr == prev_addr + AW'(1))); // R2
    AST_RD_ON_READY: assert property (@(posedge clk) disable iff (rst)
        dev_rd |-> dev_ready); // R3
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !dev_rd)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_wr) |=> irq); // R8
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && dev_rd)); // R10

endmodule

bind dma_dev2mem dma_dev2mem_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst),
    .go_wr(cfg_we && (cfg_sel == dma_pkg::SEL_CTRL) && cfg_wdata[dma_pkg::CTRL_GO_BIT]),
    .clr_wr(cfg_we && (cfg_sel == dma_pkg::SEL_CTRL) && cfg_wdata[dma_pkg::CTRL_CLR_BIT]),
    .dev_ready(dev_ready), .dev_rd(dev_rd), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy), .irq(irq)
);

// File: tb/dma_dev2mem_tb_top.sv
module dma_dev2mem_tb_top;

    localparam int AW = 32;
    localparam int DW = 8;

    logic          clk;
    logic          rst;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          dev_ready;
    logic [DW-1:0] dev_data;
    logic          dev_rd;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic          busy;
    logic          irq;

    dma_dev2mem dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dev_ready(dev_ready), .dev_data(dev_data), .dev_rd(dev_rd), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy), .irq(irq)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] dev_q[$];
    int            errors = 0;
    int            checks = 0;
    int            writes_seen = 0;
    int            mem_lat = 0;
    int            dev_gap = 0;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // device model: offers queued bytes, drops ready after a read strobe
    initial begin : device_model
        bit rd_will;
        int gapc;
        rd_will = 0; gapc = 0; dev_ready = 1'b0; dev_data = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                dev_ready = 1'b0; rd_will = 0; gapc = 0;
            end else if (rd_will) begin
                dev_ready = 1'b0;
                void'(dev_q.pop_front());
                gapc = 0;
            end else if (!dev_ready && dev_q.size() > 0) begin
                if (gapc >= dev_gap) begin
                    dev_ready = 1'b1;
                    dev_data  = dev_q[0];
                end else begin
                    gapc++;
                end
            end
            #1;
            rd_will = dev_rd;
        end
    end

    // memory model and scoreboard monitor
    initial begin : memory_monitor
        bit            ack_will;
        bit            held;
        int            wc;
        logic [AW-1:0] h_a;
        logic [DW-1:0] h_d;
        exp_t          e;
        ack_will = 0; held = 0; wc = 0; h_a = '0; h_d = '0; mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (ack_will) begin
                mem_ack = 1'b0; wc = 0;
            end else if (mem_req && !rst) begin
                if (wc >= mem_lat) mem_ack = 1'b1;
                else wc++;
            end
            #1;
            ack_will = mem_req && mem_ack;
            if (mem_req && dev_rd) chk(0, "R10", "read and write together", 1, 0);
            if (held) chk(mem_req && mem_addr == h_a && mem_wdata == h_d, "R5", "held write changed",
                          mem_addr, h_a);
            held = mem_req && !mem_ack;
            h_a = mem_addr; h_d = mem_wdata;
            if (ack_will) begin
                writes_seen++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected write", mem_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R2", "write address", mem_addr, e.a);
                    chk(mem_wdata == e.d, "R4", "write data", AW'(mem_wdata), AW'(e.d));
                end
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] s, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq();
        int t;
        t = 0;
        while (!irq && t < 5000) begin
            @(negedge clk);
            t++;
        end
        #2;
    endtask

    // driver: pushes expected writes and device bytes, then runs one transfer
    task automatic run_xfer(input int n, input logic [AW-1:0] base, input logic [DW-1:0] seed,
                            input int lat, input int gap, input bit withhold, input bit poke_mid);
        int            base_w;
        logic [DW-1:0] b;
        mem_lat = lat; dev_gap = gap; base_w = writes_seen;
        for (int i = 0; i < n; i++) begin
            b = seed + DW'(i * 37);
            exp_q.push_back('{a: base + AW'(i), d: b});
            if (!withhold) dev_q.push_back(b);
        end
        cfg_wr(2'd0, AW'(n));
        cfg_wr(2'd1, base);
        cfg_wr(2'd2, 32'h1);
        if (withhold) begin
            repeat (20) @(negedge clk);
            #2;
            chk(busy == 1'b1, "R3", "busy while device empty", AW'(busy), 1);
            chk(mem_req == 1'b0, "R3", "no write while device empty", AW'(mem_req), 0);
            chk(dev_rd == 1'b0, "R3", "no read while not ready", AW'(dev_rd), 0);
            for (int i = 0; i < n; i++) dev_q.push_back(seed + DW'(i * 37));
        end
        if (poke_mid) begin
            repeat (4) @(negedge clk);
            cfg_wr(2'd1, 32'h0000_9000);
            cfg_wr(2'd0, 32'd40);
            cfg_wr(2'd2, 32'h1);
            #2;
            chk(busy == 1'b1, "R9", "still in original transfer", AW'(busy), 1);
        end
        wait_irq();
        chk(irq == 1'b1, "R6", "irq after last byte", AW'(irq), 1);
        chk(busy == 1'b0, "R6", "idle after last byte", AW'(busy), 0);
        chk(writes_seen - base_w == n, "R6", "write count", AW'(writes_seen - base_w), AW'(n));
        chk(exp_q.size() == 0, "R2", "all expected writes seen", AW'(exp_q.size()), 0);
        repeat (8) @(negedge clk);
        #2;
        chk(writes_seen - base_w == n, "R9", "no writes after completion",
            AW'(writes_seen - base_w), AW'(n));
        cfg_wr(2'd2, 32'h2);
        #2;
        chk(irq == 1'b0, "R8", "irq cleared by write-one", AW'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int w0;
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(busy == 1'b0, "R1", "busy at reset", AW'(busy), 0);
        chk(irq == 1'b0, "R1", "irq at reset", AW'(irq), 0);
        chk(mem_req == 1'b0, "R1", "mem_req at reset", AW'(mem_req), 0);
        chk(dev_rd == 1'b0, "R1", "dev_rd at reset", AW'(dev_rd), 0);

        run_xfer(5, 32'h0000_1000, 8'h11, 0, 0, 0, 0);
        run_xfer(8, 32'h0000_2FFE, 8'hA0, 3, 2, 0, 0);
        run_xfer(1, 32'hFFFF_FFFF, 8'h5C, 1, 0, 0, 0);
        run_xfer(3, 32'h0000_4000, 8'h07, 2, 1, 1, 0);
        run_xfer(6, 32'h0000_0100, 8'hE3, 2, 1, 0, 1);

        // R7: zero length completes at once with no write
        w0 = writes_seen;
        cfg_wr(2'd0, 32'd0);
        cfg_wr(2'd2, 32'h1);
        #2;
        chk(irq == 1'b1, "R7", "irq on zero length", AW'(irq), 1);
        chk(busy == 1'b0, "R7", "not busy on zero length", AW'(busy), 0);
        repeat (10) @(negedge clk);
        #2;
        chk(writes_seen == w0, "R7", "no write on zero length", AW'(writes_seen), AW'(w0));

        // R8: control write without clear bit keeps the flag
        cfg_wr(2'd2, 32'h0);
        #2;
        chk(irq == 1'b1, "R8", "irq kept without clear bit", AW'(irq), 1);
        cfg_wr(2'd3, 32'hFFFF_FFFF);
        #2;
        chk(irq == 1'b1, "R8", "irq kept on unmapped write", AW'(irq), 1);
        cfg_wr(2'd2, 32'h2);
        #2;
        chk(irq == 1'b0, "R8", "irq cleared", AW'(irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule